// File: doc/BRIEF.md
# Block-Scaled FP8 to Single-Precision Expander

This block takes one microscaled group of thirty-two 8-bit floating-point codes (4 exponent bits, 3 mantissa bits, exponent bias 7) together with one unsigned 8-bit power-of-two scale that the whole group shares. It returns the group as thirty-two IEEE-754 binary32 words, one word per cycle, under a valid/ready handshake.

Each element is decoded into a sign, an unbiased exponent and a 3-bit fraction. Subnormal elements are normalized first. The shared scale is then applied by adding it, as an integer, to that exponent; no floating-point multiplier is used. The result is packed as a binary32 normal, a binary32 denormal or a signed infinity. Reserved codes in either the element or the scale produce the canonical quiet NaN.

A producer presents a whole group in one transfer. The consumer drains it in index order and sees a last flag on the final word. A new group is taken only after that final word has been consumed.

Top module: `mx8_block_dequant`

## Requirements
- R1: `in_ready` is high exactly when no group is held, and a group is captured on a cycle with `in_valid` and `in_ready` both high. Element i sits in `in_elems[8*i+7:8*i]`. Bit 7 of an element is its sign, bits 6:3 its exponent field and bits 2:0 its mantissa field.
- R2: From the cycle after capture, `out_valid` stays high until the last word is taken. Words come out in element order 0 to 31, and `out_last` is high only with element 31. After that word is taken, `out_valid` is low and `in_ready` is high.
- R3: An element with exponent field E from 1 to 15 (and not the NaN code) yields the exact binary32 value of (-1)^s * (1 + M/8) * 2^(E-7) * 2^(c-127), where c is the scale code and M is the mantissa field.
- R4: An element with exponent field 0 and mantissa field M other than 0 has the value M * 2^-9. It is normalized before the scale is added and yields the exact binary32 value of M * 2^-9 * 2^(c-127).
- R5: An element whose low seven bits are all zero yields signed zero (0x00000000 or 0x80000000) for every scale code except 0xFF.
- R6: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values.
- R7: Element codes 0x7F and 0xFF yield 0x7FC00000.
- R8: Scale code 0xFF makes all 32 words of the group 0x7FC00000.
- R9: A scaled value at or above 2^128 yields signed infinity (0x7F800000 with the element's sign).
- R10: A scaled value below 2^-126 yields the exact binary32 denormal (exponent field 0). Every such value of this block is at least 2^-136, so no rounding occurs.
- R11: `in_valid`, `in_elems` and `in_scale` have no effect while a group is held; the words being drained still come from the captured group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | A group is offered |
| in_ready | output | 1 | No group is held; an offer is taken |
| in_elems | input | 256 | 32 FP8 element codes, element i in bits 8*i+7:8*i |
| in_scale | input | 8 | Shared power-of-two scale code, exponent = code - 127, 0xFF = NaN |
| out_valid | output | 1 | `out_data` holds a result word |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_data | output | 32 | Binary32 result for the current element |
| out_last | output | 1 | Current word belongs to element 31 |

## Verification
The assertions assume that `in_elems` and `in_scale` matter only on the capture cycle. They also assume `out_ready` may follow any pattern, so they compare the first output word with the inputs sampled at capture. They count handshakes in the checker instead of trusting the stimulus order. The stimulus offers groups only through the handshake and drains them with both a steady and a pseudo-random `out_ready`. While a group is held, it keeps `in_valid` high with corrupted data, which exercises the ignore rule. It picks scale codes (0, 3, 100, 127, 140, 254, 255) that drive results into the normal, denormal, infinite and NaN regions.

// File: rtl/mx8_pkg.sv
package mx8_pkg;

  // element format: sign, exponent field, mantissa field
  localparam int ELEM_W     = 8;
  localparam int ELEM_EXP_W = 4;
  localparam int ELEM_MAN_W = 3;
  localparam int ELEM_BIAS  = 7;

  // shared scale: unsigned biased exponent, all-ones reserved
  localparam int SCALE_W    = 8;
  localparam int SCALE_BIAS = 127;
  localparam logic [SCALE_W-1:0] SCALE_NAN = '1;

  // binary32 result
  localparam int F32_W     = 32;
  localparam int F32_EXP_W = 8;
  localparam int F32_MAN_W = 23;
  localparam int F32_BIAS  = 127;
  localparam logic [F32_W-1:0] F32_QNAN = 32'h7FC0_0000;

  // signed working exponent, wide enough for element exponent plus scale code
  localparam int SUM_W = F32_EXP_W + 3;

  typedef struct packed {
    logic                    sign;
    logic                    is_zero;
    logic                    is_nan;
    logic signed [SUM_W-1:0] exp;
    logic [ELEM_MAN_W-1:0]   frac;
  } elem_dec_t;

endpackage

// File: rtl/mx8_rst_sync.sv
module mx8_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_no = stage_q[1];

endmodule

// File: rtl/mx8_block_ctrl.sv
module mx8_block_ctrl
  import mx8_pkg::*;
#(
  parameter int N_ELEM = 32
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic                     in_valid,
  input  logic [N_ELEM*ELEM_W-1:0] in_elems,
  input  logic [SCALE_W-1:0]       in_scale,
  input  logic                     out_ready,
  output logic                     in_ready,
  output logic                     out_valid,
  output logic                     out_last,
  output logic [ELEM_W-1:0]        elem_code,
  output logic [SCALE_W-1:0]       scale_code
);

  localparam int IDX_W = (N_ELEM > 1) ? $clog2(N_ELEM) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ELEM - 1);

  logic                     busy_q, busy_d;
  logic [IDX_W-1:0]         idx_q, idx_d;
  logic [N_ELEM*ELEM_W-1:0] elems_q;
  logic [SCALE_W-1:0]       scale_q;
  logic                     load, advance, at_last;
  logic [ELEM_W-1:0]        lane [N_ELEM];

  assign at_last = (idx_q == LAST_IDX);
  assign load    = in_valid && !busy_q;
  assign advance = busy_q && out_ready;

  // next-state logic
  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (load) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (advance) begin
      if (at_last) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  // group storage, written only when idle
  always_ff @(posedge clk) begin
    if (load) begin
      elems_q <= in_elems;
      scale_q <= in_scale;
    end
  end

  for (genvar g = 0; g < N_ELEM; g++) begin : g_lane
    assign lane[g] = elems_q[g*ELEM_W +: ELEM_W];
  end

  assign elem_code  = lane[idx_q];
  assign scale_code = scale_q;
  assign in_ready   = !busy_q;
  assign out_valid  = busy_q;
  assign out_last   = busy_q && at_last;

endmodule

// File: rtl/mx8_elem_decode.sv
module mx8_elem_decode
  import mx8_pkg::*;
(
  input  logic [ELEM_W-1:0] code,
  output elem_dec_t         dec
);

  localparam int LEAD_W = (ELEM_MAN_W > 1) ? $clog2(ELEM_MAN_W) : 1;
  // a subnormal with its leading one at bit p has value 1.f * 2^(p - SUB_OFS)
  localparam int SUB_OFS = ELEM_BIAS - 1 + ELEM_MAN_W;

  logic [ELEM_EXP_W-1:0] e_fld;
  logic [ELEM_MAN_W-1:0] m_fld;
  logic [LEAD_W-1:0]     lead;

  assign e_fld = code[ELEM_W-2 -: ELEM_EXP_W];
  assign m_fld = code[ELEM_MAN_W-1:0];

  // position of the highest set mantissa bit
  always_comb begin
    lead = '0;
    for (int b = 0; b < ELEM_MAN_W; b++) begin
      if (m_fld[b]) lead = LEAD_W'(b);
    end
  end

  always_comb begin
    dec         = '0;
    dec.sign    = code[ELEM_W-1];
    dec.is_nan  = (e_fld == '1) && (m_fld == '1);
    dec.is_zero = (e_fld == '0) && (m_fld == '0);
    if (e_fld != '0) begin
      dec.exp  = signed'(SUM_W'(e_fld)) - SUM_W'(ELEM_BIAS);
      dec.frac = m_fld;
    end else begin
      dec.exp  = signed'(SUM_W'(lead)) - SUM_W'(SUB_OFS);
      dec.frac = ELEM_MAN_W'(m_fld << (ELEM_MAN_W - int'(lead)));
    end
  end

endmodule

// File: rtl/mx8_scale_apply.sv
module mx8_scale_apply
  import mx8_pkg::*;
(
  input  elem_dec_t          dec,
  input  logic [SCALE_W-1:0] scale_code,
  output logic [F32_W-1:0]   word
);

  localparam int PAD_W = F32_MAN_W - ELEM_MAN_W;
  localparam logic signed [SUM_W-1:0] BIAS_ADJ = SUM_W'(F32_BIAS - SCALE_BIAS);
  localparam logic signed [SUM_W-1:0] EXP_SAT  = SUM_W'((2**F32_EXP_W) - 1);
  localparam logic signed [SUM_W-1:0] MAX_SH   = SUM_W'(F32_MAN_W);

  logic signed [SUM_W-1:0] scale_s;
  logic signed [SUM_W-1:0] biased;
  logic signed [SUM_W-1:0] sh;
  logic [F32_MAN_W:0]      sig_full;
  logic [F32_MAN_W:0]      sig_den;

  assign scale_s  = signed'(SUM_W'(scale_code));
  // scaling is an integer add onto the element exponent
  assign biased   = dec.exp + scale_s + BIAS_ADJ;
  assign sh       = SUM_W'(1) - biased;
  assign sig_full = {1'b1, dec.frac, {PAD_W{1'b0}}};
  assign sig_den  = sig_full >> sh[$clog2(F32_MAN_W+1):0];

  always_comb begin
    word = '0;
    if ((scale_code == SCALE_NAN) || dec.is_nan) begin
      word = F32_QNAN;
    end else if (dec.is_zero) begin
      word = {dec.sign, {(F32_W-1){1'b0}}};
    end else if (biased >= EXP_SAT) begin
      word = {dec.sign, {F32_EXP_W{1'b1}}, {F32_MAN_W{1'b0}}};
    end else if (biased >= SUM_W'(1)) begin
      word = {dec.sign, biased[F32_EXP_W-1:0], dec.frac, {PAD_W{1'b0}}};
    end else if (sh <= MAX_SH) begin
      word = {dec.sign, {F32_EXP_W{1'b0}}, sig_den[F32_MAN_W-1:0]};
    end else begin
      word = {dec.sign, {(F32_W-1){1'b0}}};
    end
  end

endmodule

// File: rtl/mx8_block_dequant.sv
module mx8_block_dequant
  import mx8_pkg::*;
#(
  parameter int N_ELEM = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [N_ELEM*ELEM_W-1:0] in_elems,
  input  logic [SCALE_W-1:0]       in_scale,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [F32_W-1:0]         out_data,
  output logic                     out_last
);

  logic              rst_sync_n;
  logic [ELEM_W-1:0] elem_code;
  logic [SCALE_W-1:0] scale_code;
  elem_dec_t         dec;

  mx8_rst_sync i_rst_sync (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_sync_n)
  );

  mx8_block_ctrl #(.N_ELEM(N_ELEM)) i_ctrl (
    .clk        (clk),
    .rst_ni     (rst_sync_n),
    .in_valid   (in_valid),
    .in_elems   (in_elems),
    .in_scale   (in_scale),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_last   (out_last),
    .elem_code  (elem_code),
    .scale_code (scale_code)
  );

  mx8_elem_decode i_decode (
    .code (elem_code),
    .dec  (dec)
  );

  mx8_scale_apply i_apply (
    .dec        (dec),
    .scale_code (scale_code),
    .word       (out_data)
  );

endmodule

// File: rtl/mx8_block_dequant_chk.sv
module mx8_block_dequant_chk
  import mx8_pkg::*;
#(
  parameter int N_ELEM = 32
) (
  input logic                     clk,
  input logic                     rst_ni,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic [N_ELEM*ELEM_W-1:0] in_elems,
  input logic [SCALE_W-1:0]       in_scale,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [F32_W-1:0]         out_data,
  input logic                     out_last
);

  localparam int CW = (N_ELEM > 1) ? $clog2(N_ELEM) : 1;

  logic [CW-1:0] taken_q;
  logic          accept, fire;

  assign accept = in_valid && in_ready;
  assign fire   = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_q <= '0;
    end else if (accept) begin
      taken_q <= '0;
    end else if (fire) begin
      taken_q <= (taken_q == CW'(N_ELEM - 1)) ? '0 : taken_q + CW'(1);
    end
  end

  // R1: capture starts a group and closes the input
  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_ni)
    accept |=> (out_valid && !in_ready));

  // R11: no offer is taken while a group is held
  a_r11_no_accept: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid |-> !in_ready);

  // R2: last flag marks the final handshake of a group
  a_r2_last_pos: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid |-> (out_last == (taken_q == CW'(N_ELEM - 1))));

  // R6: stalled output holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R8: reserved scale poisons the first word
  a_r8_nan_scale: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && (in_scale == SCALE_NAN)) |=> (out_data == F32_QNAN));

  // R5: zero element 0 stays signed zero
  a_r5_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && (in_scale != SCALE_NAN) && (in_elems[ELEM_W-2:0] == '0))
      |=> (out_data == {$past(in_elems[ELEM_W-1]), {(F32_W-1){1'b0}}}));

endmodule

bind mx8_block_dequant mx8_block_dequant_chk #(.N_ELEM(N_ELEM)) i_chk (
  .clk       (clk),
  .rst_ni    (rst_sync_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_elems  (in_elems),
  .in_scale  (in_scale),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last)
);

// File: tb/test_mx8_block_dequant.sv
`timescale 1ns/1ps
module test_mx8_block_dequant;

  localparam int  NE  = 32;
  localparam time CLK = 10ns;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [NE*8-1:0] in_elems;
  logic [7:0]    in_scale;
  logic          out_valid;
  logic          out_ready;
  logic [31:0]   out_data;
  logic          out_last;

  int  n_tests;
  int  n_fail;
  bit  done;
  logic [15:0] lfsr;

  mx8_block_dequant i_mx8_block_dequant (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_elems  (in_elems),
    .in_scale  (in_scale),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
  );

  initial clk = 1'b0;
  always #(CLK/2) clk = ~clk;

  // behavioural reference: value = sig * 2^k, renormalized with integers
  function automatic logic [31:0] ref_word(input logic [7:0] e, input logic [7:0] sc);
    int sig;
    int k;
    int be;
    logic s;
    logic [31:0] w;
    s = e[7];
    if (sc == 8'hFF || e[6:0] == 7'h7F) return 32'h7FC0_0000;
    if (e[6:0] == 7'h00) return {s, 31'b0};
    if (e[6:3] == 4'd0) begin
      sig = int'(e[2:0]);
      k   = -9;
    end else begin
      sig = 8 + int'(e[2:0]);
      k   = int'(e[6:3]) - 10;
    end
    k = k + int'(sc) - 127;
    while (sig < 8) begin
      sig = sig * 2;
      k   = k - 1;
    end
    be = k + 3 + 127;
    if (be >= 255) return {s, 8'hFF, 23'b0};
    if (be >= 1) begin
      w = {s, be[7:0], sig[2:0], 20'b0};
      return w;
    end
    sig = sig << (k + 149);
    w = {s, 8'h00, sig[22:0]};
    return w;
  endfunction

  function automatic string req_of(input logic [7:0] e, input logic [7:0] sc);
    logic [31:0] w;
    if (sc == 8'hFF) return "R8";
    if (e[6:0] == 7'h7F) return "R7";
    if (e[6:0] == 7'h00) return "R5";
    w = ref_word(e, sc);
    if (w[30:23] == 8'hFF) return "R9";
    if (w[30:23] == 8'h00) return "R10";
    if (e[6:3] == 4'd0) return "R4";
    return "R3";
  endfunction

  function automatic logic [NE*8-1:0] gen_block(input int seed);
    logic [NE*8-1:0] b;
    for (int i = 0; i < NE; i++) b[8*i +: 8] = 8'((i * 53 + seed * 17 + 11) & 255);
    return b;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // offer one group, then drain it while comparing every cycle
  task automatic run_block(input logic [NE*8-1:0] blk, input logic [7:0] sc,
                           input bit stall, input bit flood);
    logic [31:0] q_exp[$];
    string       q_req[$];
    bit          rdy;
    for (int i = 0; i < NE; i++) begin
      q_exp.push_back(ref_word(blk[8*i +: 8], sc));
      q_req.push_back(req_of(blk[8*i +: 8], sc));
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_elems = blk;
    in_scale = sc;
    out_ready = 1'b0;
    #1;
    check(in_ready == 1'b1, "R1", {31'b0, in_ready}, 32'd1);
    @(negedge clk);
    if (flood) begin
      in_elems = ~blk;       // R11: offered while busy, must be ignored
      in_scale = sc ^ 8'h5A;
    end else begin
      in_valid = 1'b0;
    end
    while (q_exp.size() > 0) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
      out_ready = rdy;
      #1;
      check(out_valid == 1'b1, "R2", {31'b0, out_valid}, 32'd1);
      check(in_ready == 1'b0, "R11", {31'b0, in_ready}, 32'd0);
      check(out_data == q_exp[0], rdy ? q_req[0] : "R6", out_data, q_exp[0]);
      check(out_last == (q_exp.size() == 1), "R2",
            {31'b0, out_last}, {31'b0, q_exp.size() == 1});
      if (rdy) begin
        void'(q_exp.pop_front());
        void'(q_req.pop_front());
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b0;
    #1;
    check(out_valid == 1'b0, "R2", {31'b0, out_valid}, 32'd0);
    check(in_ready == 1'b1, "R2", {31'b0, in_ready}, 32'd1);
  endtask

  initial begin
    logic [NE*8-1:0] b;
    n_tests   = 0;
    n_fail    = 0;
    done      = 1'b0;
    lfsr      = 16'hACE1;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_elems  = '0;
    in_scale  = 8'd127;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1", {31'b0, out_valid}, 32'd0);
    check(in_ready == 1'b1, "R1", {31'b0, in_ready}, 32'd1);

    // unit scale with hand-picked codes: one, max, -max, zeros, NaNs, subnormals
    b = gen_block(1);
    b[7:0]   = 8'h38; b[15:8]  = 8'h7E; b[23:16] = 8'hFE; b[31:24] = 8'h00;
    b[39:32] = 8'h80; b[47:40] = 8'h7F; b[55:48] = 8'hFF; b[63:56] = 8'h01;
    b[71:64] = 8'h07; b[79:72] = 8'h83; b[87:80] = 8'h08; b[95:88] = 8'h3F;
    run_block(b, 8'd127, 1'b0, 1'b0);

    run_block(gen_block(2), 8'hFF, 1'b1, 1'b0);   // R8 with stalls (R6)

    b = gen_block(3);
    b[7:0] = 8'h38; b[15:8] = 8'h40; b[23:16] = 8'hC0; b[31:24] = 8'h80;
    run_block(b, 8'd254, 1'b1, 1'b1);             // R9 and ignored offers

    b = gen_block(4);
    b[7:0] = 8'h01; b[15:8] = 8'h81; b[23:16] = 8'h38; b[31:24] = 8'h00;
    run_block(b, 8'd0, 1'b0, 1'b1);               // R10 deepest denormals

    run_block(gen_block(5), 8'd3, 1'b1, 1'b0);
    run_block(gen_block(6), 8'd140, 1'b0, 1'b0);
    run_block(gen_block(7), 8'd100, 1'b1, 1'b1);
    run_block(gen_block(8), 8'd127, 1'b0, 1'b0);  // back-to-back reuse

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule